// File: doc/BRIEF.md
# Multi-Ring Data Transfer Arbiter

This block is the central data arbiter of an on-chip interconnect in which twelve bus elements sit on four unidirectional data rings. Two rings move data clockwise and two move it counter-clockwise, and each ring is 16 bytes wide. Every element can post one transfer request naming a destination element. The arbiter chooses the direction with the shorter path, picks one of the two rings running that way, and grants the request only when every ring link on the path is unused. Disjoint transfers may share a ring, up to three at a time. The ring topology stays hidden from the elements: they see only a grant and later hand back a release.

Arbitration has two stages with one round-robin pointer each. The first stage chooses one eligible requesting element, starting from the element after the last one granted. The second stage chooses a ring within the selected direction, starting from the ring after the one that direction used last. The arbiter makes at most one grant per cycle. Each granted transfer holds a slot on its ring, and that slot keeps its links reserved until a release names it.

Requests follow a valid/ready handshake. `req_valid[i]` with `req_dst` forms the valid side, and `req_ready[i]` is ready. A waiting requester holds its destination steady. It may drop `req_valid` to withdraw, and it sees back-pressure for as long as `req_ready` stays low. Grant and release pins are plain control signals.

Top module: `ring_data_arb`

## Requirements
- R1: After reset all slots are empty, `ring_occ` is zero and no grant is made. The element pointer starts at element 0, and each direction first prefers its lower ring.
- R2: The clockwise distance is d = (dst - src) mod 12. If d <= 6 the transfer uses the clockwise rings 0 and 1 and holds d links. Otherwise it uses the counter-clockwise rings 2 and 3 and holds 12 - d links. Occupancy bit `ring_occ[r*12+k]` stands for link k of ring r. On rings 0 and 1, link k joins element k to element k+1. On rings 2 and 3, link k joins element k to element k-1. All indices are taken mod 12.
- R3: A transfer is granted on a ring only when none of its links are already held there. Transfers with disjoint links may share a ring, and `gnt_valid` is high exactly when some request is eligible.
- R4: A ring holds at most three transfers. A new grant takes the lowest free slot index (0, 1 or 2), reported on `gnt_slot`.
- R5: No request is granted while its destination is the destination of an active transfer. No request is granted while its source is the source of an active transfer.
- R6: A request whose destination equals its own element, or whose destination is 12 or higher, is never granted.
- R7: The arbiter makes at most one grant per cycle. It grants the first eligible element found scanning upward (with wrap) from the element pointer, and the pointer then moves to the granted element plus one.
- R8: Within the chosen direction, the ring after the one that direction granted last is tried first. If the transfer does not fit on that ring, the other ring of the same direction is used.
- R9: A grant is combinational in the request cycle: `req_ready`, `gnt_valid`, `gnt_src`, `gnt_dst`, `gnt_ring` and `gnt_slot` are all valid in that cycle. Its links appear in `ring_occ` from the next cycle. A waiting requester keeps `req_dst` steady and may withdraw.
- R10: A release (`rel_valid`, `rel_ring`, `rel_slot`) frees the named slot at the next clock edge. A release naming an empty slot, or slot index 3, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 12 | Per-element request valid |
| req_dst | input | 48 | Per-element destination, 4 bits per element, element i at bits 4i+3:4i |
| req_ready | output | 12 | Per-element grant (ready of the request handshake) |
| gnt_valid | output | 1 | A grant is made this cycle |
| gnt_src | output | 4 | Granted source element |
| gnt_dst | output | 4 | Granted destination element |
| gnt_ring | output | 2 | Ring carrying the grant |
| gnt_slot | output | 2 | Slot on that ring holding the transfer |
| rel_valid | input | 1 | Release strobe |
| rel_ring | input | 2 | Ring of the slot to release |
| rel_slot | input | 2 | Slot index to release |
| ring_occ | output | 48 | Link occupancy, 12 bits per ring |

## Verification
The assertions assume that a requester left waiting keeps the same destination on the next cycle unless it withdraws. They place no limits on releases, which may name any ring and slot, including empty or out-of-range ones. The bench keeps a pending table per element, so a destination is only written while its valid is low. Pending requests are withdrawn at random, random releases aim at both busy and idle slots, and now and then a destination that must never be granted is posted.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  typedef enum logic {DIR_CW = 1'b0, DIR_CCW = 1'b1} ring_dir_e;
endpackage

// File: rtl/ring_arb_rr.sv
module ring_arb_rr #(
  parameter int W = 12,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < W; k++) begin
      int c;
      c = int'(ptr) + k;
      if (c >= W) c = c - W;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/ring_arb_track.sv
module ring_arb_track #(
  parameter int N     = 12,
  parameter int SLOTS = 3,
  localparam int EW = $clog2(N),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [EW-1:0] alloc_src,
  input  logic [EW-1:0] alloc_dst,
  input  logic [N-1:0]  alloc_mask,
  input  logic          rel_en,
  input  logic [SW-1:0] rel_slot,
  output logic [N-1:0]  occ,
  output logic          free_any,
  output logic [SW-1:0] free_idx,
  output logic [N-1:0]  src_use,
  output logic [N-1:0]  dst_use
);
  logic [SLOTS-1:0] sv;
  logic [N-1:0]     smask [SLOTS];
  logic [EW-1:0]    ssrc  [SLOTS];
  logic [EW-1:0]    sdst  [SLOTS];

  always_comb begin
    occ      = '0;
    src_use  = '0;
    dst_use  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (sv[s]) begin
        occ           = occ | smask[s];
        src_use[ssrc[s]] = 1'b1;
        dst_use[sdst[s]] = 1'b1;
      end else begin
        free_any = 1'b1;
        free_idx = SW'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv <= '0;
    end else begin
      if (rel_en && int'(rel_slot) < SLOTS) sv[rel_slot] <= 1'b0;
      if (alloc_en) begin
        sv[free_idx]    <= 1'b1;
        smask[free_idx] <= alloc_mask;
        ssrc[free_idx]  <= alloc_src;
        sdst[free_idx]  <= alloc_dst;
      end
    end
  end

  // R3
  alloc_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> ((alloc_mask & occ) == '0));
  // R4
  alloc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_any);
  // R9
  occ_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> ((occ & $past(alloc_mask)) == $past(alloc_mask)));
endmodule

// File: rtl/ring_data_arb.sv
module ring_data_arb
  import ring_arb_pkg::*;
#(
  parameter int N     = 12,
  parameter int RINGS = 4,
  parameter int SLOTS = 3,
  localparam int EW   = $clog2(N),
  localparam int RW   = $clog2(RINGS),
  localparam int SW   = $clog2(SLOTS),
  localparam int RPD  = RINGS / 2,
  localparam int PW   = $clog2(RPD),
  localparam int HALF = N / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_valid,
  input  logic [N*EW-1:0]   req_dst,
  output logic [N-1:0]      req_ready,
  output logic              gnt_valid,
  output logic [EW-1:0]     gnt_src,
  output logic [EW-1:0]     gnt_dst,
  output logic [RW-1:0]     gnt_ring,
  output logic [SW-1:0]     gnt_slot,
  input  logic              rel_valid,
  input  logic [RW-1:0]     rel_ring,
  input  logic [SW-1:0]     rel_slot,
  output logic [RINGS*N-1:0] ring_occ
);
  function automatic int cw_dist(input int src, input int dst);
    int d;
    d = dst - src;
    if (d < 0) d = d + N;
    return d;
  endfunction

  function automatic logic [N-1:0] path_mask(input int src, input int dst, input logic ccw);
    logic [N-1:0] m;
    int hops;
    m = '0;
    hops = ccw ? N - cw_dist(src, dst) : cw_dist(src, dst);
    for (int h = 0; h < N; h++) begin
      int k;
      k = ccw ? src - h : src + h;
      if (k >= N) k = k - N;
      if (k < 0) k = k + N;
      if (h < hops) m[k] = 1'b1;
    end
    return m;
  endfunction

  logic [N-1:0]      occ_r    [RINGS];
  logic [N-1:0]      src_use  [RINGS];
  logic [N-1:0]      dst_use  [RINGS];
  logic [SW-1:0]     free_idx [RINGS];
  logic [RINGS-1:0]  free_any;
  logic [N-1:0]      src_busy;
  logic [(1<<EW)-1:0] dst_busy;

  logic [EW-1:0]     dst_e  [N];
  ring_dir_e         dir_e  [N];
  logic [N-1:0]      mask_e [N];
  logic [RPD-1:0]    fit_e  [N];
  logic [N-1:0]      elig;

  logic [EW-1:0]     ptr_e;
  logic [1:0][PW-1:0] ptr_d;
  logic              grant;
  logic [EW-1:0]     sel_idx;
  ring_dir_e         dir_sel;
  logic              ring_any;
  logic [PW-1:0]     ring_off;
  logic [N-1:0]      gnt_mask;

  always_comb begin
    src_busy = '0;
    dst_busy = '0;
    for (int r = 0; r < RINGS; r++) begin
      src_busy = src_busy | src_use[r];
      dst_busy[N-1:0] = dst_busy[N-1:0] | dst_use[r];
    end
  end

  // per-element eligibility (stage 1 input)
  for (genvar i = 0; i < N; i++) begin : g_elem
    logic [RPD-1:0] fit;
    logic           legal;
    assign dst_e[i]  = req_dst[i*EW +: EW];
    assign dir_e[i]  = (cw_dist(i, int'(dst_e[i])) > HALF) ? DIR_CCW : DIR_CW;
    assign mask_e[i] = path_mask(i, int'(dst_e[i]), dir_e[i] == DIR_CCW);
    assign legal     = (int'(dst_e[i]) < N) && (int'(dst_e[i]) != i);
    always_comb begin
      for (int j = 0; j < RPD; j++) begin
        int r;
        r = ((dir_e[i] == DIR_CCW) ? RPD : 0) + j;
        fit[j] = free_any[r] && ((mask_e[i] & occ_r[r]) == '0);
      end
    end
    assign fit_e[i] = fit;
    assign elig[i]  = req_valid[i] && legal && !src_busy[i] && !dst_busy[dst_e[i]] && (|fit);
    assign req_ready[i] = grant && (int'(sel_idx) == i);
  end

  // stage 1: element round robin
  ring_arb_rr #(.W(N)) u_elem_rr (
    .req(elig), .ptr(ptr_e), .any(grant), .idx(sel_idx)
  );

  // stage 2: ring round robin within the chosen direction
  assign dir_sel = dir_e[sel_idx];
  ring_arb_rr #(.W(RPD)) u_ring_rr (
    .req(fit_e[sel_idx]), .ptr(ptr_d[dir_sel == DIR_CCW]), .any(ring_any), .idx(ring_off)
  );

  assign gnt_valid = grant;
  assign gnt_src   = sel_idx;
  assign gnt_dst   = dst_e[sel_idx];
  assign gnt_ring  = RW'(((dir_sel == DIR_CCW) ? RPD : 0) + int'(ring_off));
  assign gnt_slot  = free_idx[gnt_ring];
  assign gnt_mask  = mask_e[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_e <= '0;
      ptr_d <= '0;
    end else if (grant) begin
      ptr_e <= (int'(sel_idx) == N - 1) ? '0 : sel_idx + 1'b1;
      ptr_d[dir_sel == DIR_CCW] <= (int'(ring_off) == RPD - 1) ? '0 : ring_off + 1'b1;
    end
  end

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    ring_arb_track #(.N(N), .SLOTS(SLOTS)) u_track (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(grant && ring_any && (gnt_ring == RW'(r))),
      .alloc_src(gnt_src), .alloc_dst(gnt_dst), .alloc_mask(gnt_mask),
      .rel_en(rel_valid && (rel_ring == RW'(r))), .rel_slot(rel_slot),
      .occ(occ_r[r]), .free_any(free_any[r]), .free_idx(free_idx[r]),
      .src_use(src_use[r]), .dst_use(dst_use[r])
    );
    assign ring_occ[r*N +: N] = occ_r[r];
  end

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  // R2
  half_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($countones(gnt_mask) <= HALF));
  // R5
  ends_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (!dst_busy[gnt_dst] && !src_busy[gnt_src]));
  // R6
  legal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ((gnt_dst != gnt_src) && (int'(gnt_dst) < N)));
  // R8
  ring_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ring_any);

  for (genvar i = 0; i < N; i++) begin : g_hold
    // R9
    dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !req_ready[i]) |=> (!req_valid[i] || $stable(req_dst[i*EW +: EW])));
  end
endmodule

// File: tb/ring_data_arb_bench.sv
module ring_data_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam int RINGS = 4;
  localparam int SLOTS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    pend = '0;
  logic [3:0]      pdst [N];
  logic [N*4-1:0]  req_dst;
  logic [N-1:0]    req_ready;
  logic            gnt_valid;
  logic [3:0]      gnt_src, gnt_dst;
  logic [1:0]      gnt_ring, gnt_slot;
  logic            rel_valid = 1'b0;
  logic [1:0]      rel_ring = '0, rel_slot = '0;
  logic [RINGS*N-1:0] ring_occ;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit          mv [RINGS][SLOTS];
  int          ms [RINGS][SLOTS];
  int          md [RINGS][SLOTS];
  logic [N-1:0] mm [RINGS][SLOTS];
  int          mpe;
  int          mpd [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < N; i++) req_dst[i*4 +: 4] = pdst[i];

  ring_data_arb u_ring_data_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(pend), .req_dst(req_dst),
    .req_ready(req_ready), .gnt_valid(gnt_valid), .gnt_src(gnt_src),
    .gnt_dst(gnt_dst), .gnt_ring(gnt_ring), .gnt_slot(gnt_slot),
    .rel_valid(rel_valid), .rel_ring(rel_ring), .rel_slot(rel_slot),
    .ring_occ(ring_occ)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_cw(int s, int d);
    return (d - s + N) % N;
  endfunction

  function automatic logic [N-1:0] m_path(int s, int d);
    logic [N-1:0] m = '0;
    int dd = m_cw(s, d);
    if (dd <= N/2) for (int h = 0; h < dd; h++) m[(s + h) % N] = 1'b1;
    else for (int h = 0; h < N - dd; h++) m[(s - h + N) % N] = 1'b1;
    return m;
  endfunction

  function automatic logic [N-1:0] m_occ(int r);
    logic [N-1:0] o = '0;
    for (int s = 0; s < SLOTS; s++) if (mv[r][s]) o = o | mm[r][s];
    return o;
  endfunction

  function automatic int m_free(int r);
    for (int s = 0; s < SLOTS; s++) if (!mv[r][s]) return s;
    return -1;
  endfunction

  function automatic bit m_busy(int e, bit as_dst);
    for (int r = 0; r < RINGS; r++)
      for (int s = 0; s < SLOTS; s++)
        if (mv[r][s] && ((as_dst ? md[r][s] : ms[r][s]) == e)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic expect_grant(output bit ok, output int es, output int er, output int esl);
    ok = 0; es = 0; er = 0; esl = 0;
    for (int k = 0; k < N; k++) begin
      int i = (mpe + k) % N;
      int d = int'(pdst[i]);
      if (!ok && pend[i] && d < N && d != i && !m_busy(i, 0) && !m_busy(d, 1)) begin
        int dc = (m_cw(i, d) > N/2) ? 1 : 0;
        logic [N-1:0] pm = m_path(i, d);
        for (int j = 0; j < 2; j++) begin
          int r = dc*2 + (mpd[dc] + j) % 2;
          int fs = m_free(r);
          if (!ok && fs >= 0 && (pm & m_occ(r)) == '0) begin
            ok = 1; es = i; er = r; esl = fs;
          end
        end
      end
    end
  endtask

  // compare against the model now, then advance the model at the next falling edge
  task automatic cyc();
    bit ok;
    int es, er, esl;
    logic [N-1:0] ev;
    logic [RINGS*N-1:0] eo;
    expect_grant(ok, es, er, esl);
    ev = ok ? (N'(1) << es) : '0;
    chk("R7 req_ready", req_ready, ev);
    chk("R3 gnt_valid", gnt_valid, ok);
    if (ok && gnt_valid) begin
      chk("R7 gnt_src", gnt_src, es);
      chk("R2 gnt_dst", gnt_dst, pdst[es]);
      chk("R8 gnt_ring", gnt_ring, er);
      chk("R4 gnt_slot", gnt_slot, esl);
    end
    for (int r = 0; r < RINGS; r++) eo[r*N +: N] = m_occ(r);
    chk("R3 ring_occ", ring_occ, eo);
    @(negedge clk);
    if (rel_valid && int'(rel_slot) < SLOTS) mv[rel_ring][rel_slot] = 0;
    if (ok) begin
      mv[er][esl] = 1; ms[er][esl] = es; md[er][esl] = int'(pdst[es]);
      mm[er][esl] = m_path(es, int'(pdst[es]));
      pend[es] = 0;
      mpe = (es + 1) % N;
      mpd[er/2] = (er % 2 + 1) % 2;
    end
    rel_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) pdst[i] = '0;
    for (int r = 0; r < RINGS; r++) for (int s = 0; s < SLOTS; s++) mv[r][s] = 0;
    mpe = 0; mpd[0] = 0; mpd[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset ring_occ", ring_occ, '0);
    chk("R1 reset gnt_valid", gnt_valid, 1'b0);
    chk("R1 reset req_ready", req_ready, '0);
    cyc();

    // 0 -> 3 clockwise, ring 0 slot 0, links 0..2
    pend[0] = 1; pdst[0] = 4'd3; #1;
    chk("R1 first cw ring", gnt_ring, 2'd0);
    chk("R9 same-cycle ready", req_ready, 12'h001);
    cyc();
    chk("R2 cw links", ring_occ, 48'h0000_0000_0007);

    // 5 -> 2: distance 9, counter-clockwise ring 2, links 5,4,3
    pend[5] = 1; pdst[5] = 4'd2; #1;
    chk("R2 ccw ring", gnt_ring, 2'd2);
    cyc();
    chk("R2 ccw links", ring_occ, 48'h0000_3800_0007);

    // destination 3 busy, source 0 busy
    pend[7] = 1; pdst[7] = 4'd3; pend[0] = 1; pdst[0] = 4'd6; #1;
    chk("R5 busy ends", gnt_valid, 1'b0);
    cyc();
    pend[7] = 0; pend[0] = 0;

    // self and out-of-range destinations
    pend[4] = 1; pdst[4] = 4'd4; pend[6] = 1; pdst[6] = 4'd14; #1;
    chk("R6 illegal dst", req_ready, '0);
    cyc();
    pend[4] = 0; pend[6] = 0;

    // ring pointer: ring 1 preferred after ring 0 was used
    pend[8] = 1; pdst[8] = 4'd10; #1;
    chk("R8 alternate ring", gnt_ring, 2'd1);
    cyc();
    // 11 -> 1 blocked on preferred ring 0 at link 0, shares ring 1
    pend[11] = 1; pdst[11] = 4'd1; #1;
    chk("R8 fallback ring", gnt_ring, 2'd1);
    chk("R4 second slot", gnt_slot, 2'd1);
    cyc();

    // releases: real, empty slot, out-of-range slot
    rel_valid = 1; rel_ring = 2'd0; rel_slot = 2'd0; #1;
    cyc();
    chk("R10 release frees", ring_occ, 48'h0000_38B0_1000);
    rel_valid = 1; rel_ring = 2'd3; rel_slot = 2'd0; #1;
    cyc();
    chk("R10 empty release", ring_occ, 48'h0000_38B0_1000);
    rel_valid = 1; rel_ring = 2'd2; rel_slot = 2'd3; #1;
    cyc();
    chk("R10 bad slot release", ring_occ, 48'h0000_38B0_1000);

    // element round robin from pointer 0: 3 before 6
    pend[3] = 1; pdst[3] = 4'd4; pend[6] = 1; pdst[6] = 4'd7; #1;
    chk("R7 rr first", gnt_src, 4'd3);
    cyc();
    #1;
    chk("R7 rr second", gnt_src, 4'd6);
    chk("R4 third slot", gnt_slot, 2'd2);
    cyc();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (!pend[i] && ($urandom % 4) == 0) begin
          pend[i] = 1;
          pdst[i] = (($urandom % 10) == 0) ? 4'($urandom % 16) : 4'($urandom % N);
        end else if (pend[i] && ($urandom % 12) == 0) begin
          pend[i] = 0;
        end
      end
      if (($urandom % 2) == 0) begin
        rel_valid = 1; rel_ring = 2'($urandom % 4); rel_slot = 2'($urandom % 4);
      end
      #1;
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule